// File: doc/BRIEF.md
# Sliding Sub-Area Cross-Correlator

This block measures how well a small patch of a first image matches every shifted position inside a larger window of a second image. The patch (the sub-area) is taken from the centre of the first-frame window buffer. It is laid over the second-frame window at every offset the step size allows. At each offset the block multiplies the overlapping pixel pairs and sums the products, which gives a direct spatial cross-correlation. Each finished sum is written to an internal result memory at an address formed from its offset indices. A later peak-search stage reads those sums through a separate read port.

Both image buffers sit outside the block and answer an address with data one clock later. One `start` pulse scans all offsets. One multiply-accumulate is done per clock, and a single-cycle `done` pulse follows the write of the last sum. All sizes are parameters, and so are the step and the pixel width. The number of offsets and every width are derived from them.

Top module: `subarea_correlator`

## Requirements
- R1: After reset, `done` is low and, while idle, `sub_addr` points at the sub-area origin `SY0*WIN_W+SX0`, with `SX0=(WIN_W-SUB_W)/2` and `SY0=(WIN_D-SUB_D)/2`, and `win_addr` is 0. Both buffers are addressed row-major: pixel (x,y) of a window is at `y*WIN_W+x`.
- R2: For offset (s,t), the stored value equals the sum over 0≤x<SUB_W and 0≤y<SUB_D of A[(y+SY0)*WIN_W+x+SX0] · B[(y+t*STEP)*WIN_W+x+s*STEP], as an unsigned value. A is the first-frame buffer and B is the second-frame buffer.
- R3: The result width is 2·PIX_W+ceil(log2(SUB_W·SUB_D)) bits, and all-maximum pixels give the exact value SUB_W·SUB_D·(2^PIX_W−1)^2 with no wrap.
- R4: There are NS=(WIN_W−SUB_W)/STEP+1 horizontal and NT=(WIN_D−SUB_D)/STEP+1 vertical offsets. The sum for offset (s,t) is stored at result address t·NS+s. s varies fastest.
- R5: The STEP parameter sets the offset stride in pixels. With STEP=2 on the same window and sub-area sizes, the offset count and the contents follow R2 and R4.
- R6: One product is accumulated per clock. `done` is high exactly NS·NT·SUB_W·SUB_D+2 clocks after the edge that samples `start`.
- R7: `done` is a one-clock pulse that follows the write of the last sum. The result memory then already holds every sum of the run.
- R8: `start` is ignored while a scan is running. A pulse mid-scan neither restarts the scan, changes any stored sum, nor produces a second `done`.
- R9: `res_rd_data` returns the sum stored at `res_rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a full scan of all offsets |
| sub_addr | output | BUF_AW | Read address into the first-frame window buffer |
| sub_pix | input | PIX_W | First-frame pixel, one clock after `sub_addr` |
| win_addr | output | BUF_AW | Read address into the second-frame window buffer |
| win_pix | input | PIX_W | Second-frame pixel, one clock after `win_addr` |
| res_rd_addr | input | RES_AW | Result memory read address |
| res_rd_data | output | ACC_W | Stored sum, one clock after `res_rd_addr` |
| done | output | 1 | One-clock pulse after the last sum is stored |

## Verification
Full-scale pixels drive the sum to its largest value. An accumulator one bit short would wrap there and store a small number. Affine and quadratic pixel ramps make every offset produce a different sum. If the horizontal and vertical indices were swapped, or the result address was formed the wrong way round, the sums would land at the wrong addresses. A misaligned pipeline would either add a pixel of the next offset or lose the first product of each offset. A second configuration with a stride of two catches a step that is applied to only one axis, and a `start` pulse mid-scan catches a generator that restarts instead of ignoring it. The start-to-done cycle count shows any stall or extra pipeline stage.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic {
        CC_IDLE = 1'b0,
        CC_RUN  = 1'b1
    } cc_phase_e;

    // counter width able to hold values 0 .. n-1, never zero
    function automatic int unsigned cc_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // number of placements of a sub-area along one axis
    function automatic int unsigned cc_positions(input int unsigned win,
                                                 input int unsigned sub,
                                                 input int unsigned step);
        return (win - sub) / step + 1;
    endfunction

endpackage

// File: rtl/cc_addr_gen.sv
module cc_addr_gen
    import cc_pkg::*;
#(
    parameter int WIN_W  = 40,
    parameter int WIN_D  = 40,
    parameter int SUB_W  = 32,
    parameter int SUB_D  = 32,
    parameter int STEP   = 1,
    parameter int BUF_AW = 11,
    parameter int RES_AW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [BUF_AW-1:0] sub_addr,
    output logic [BUF_AW-1:0] win_addr,
    output logic              tap_valid,
    output logic              tap_first,
    output logic              tap_last,
    output logic              tap_final,
    output logic [RES_AW-1:0] tap_idx
);
    localparam int NS  = int'(cc_positions(WIN_W, SUB_W, STEP));
    localparam int NT  = int'(cc_positions(WIN_D, SUB_D, STEP));
    localparam int XW  = int'(cc_bits(SUB_W));
    localparam int YW  = int'(cc_bits(SUB_D));
    localparam int SCW = int'(cc_bits(NS));
    localparam int TCW = int'(cc_bits(NT));
    localparam int SX0 = (WIN_W - SUB_W) / 2;
    localparam int SY0 = (WIN_D - SUB_D) / 2;

    typedef struct packed {
        cc_phase_e      ph;
        logic [XW-1:0]  x;
        logic [YW-1:0]  y;
        logic [SCW-1:0] s;
        logic [TCW-1:0] t;
    } ag_t;

    ag_t q, d;
    logic x_end, y_end, s_end, t_end;

    always_comb begin
        x_end = (q.x == XW'(SUB_W - 1));
        y_end = (q.y == YW'(SUB_D - 1));
        s_end = (q.s == SCW'(NS - 1));
        t_end = (q.t == TCW'(NT - 1));
        d = q;
        case (q.ph)
            CC_IDLE: begin
                if (start) begin
                    d.ph = CC_RUN;
                    d.x  = '0;
                    d.y  = '0;
                    d.s  = '0;
                    d.t  = '0;
                end
            end
            default: begin
                if (!x_end) begin
                    d.x = q.x + 1'b1;
                end else begin
                    d.x = '0;
                    if (!y_end) begin
                        d.y = q.y + 1'b1;
                    end else begin
                        d.y = '0;
                        if (!s_end) begin
                            d.s = q.s + 1'b1;
                        end else begin
                            d.s = '0;
                            if (!t_end) begin
                                d.t = q.t + 1'b1;
                            end else begin
                                d.t  = '0;
                                d.ph = CC_IDLE;
                            end
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: CC_IDLE, x: '0, y: '0, s: '0, t: '0};
        end else begin
            q <= d;
        end
    end

    assign tap_valid = (q.ph == CC_RUN);
    assign tap_first = (q.x == '0) && (q.y == '0);
    assign tap_last  = x_end && y_end;
    assign tap_final = x_end && y_end && s_end && t_end;
    assign tap_idx   = RES_AW'(int'(q.t) * NS + int'(q.s));
    assign sub_addr  = BUF_AW'((int'(q.y) + SY0) * WIN_W + int'(q.x) + SX0);
    assign win_addr  = BUF_AW'((int'(q.y) + int'(q.t) * STEP) * WIN_W
                               + int'(q.x) + int'(q.s) * STEP);

    // R1, R2: every issued read lies inside a window buffer
    a_r2_addr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        tap_valid |-> (int'(sub_addr) < WIN_W * WIN_D) && (int'(win_addr) < WIN_W * WIN_D));

    // R4: offsets are visited in order, one index per new shift
    a_r4_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_valid && tap_first && tap_idx != '0) |-> (tap_idx == $past(tap_idx) + 1'b1));

    // R6, R8: a running scan is never interrupted mid-shift
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_valid && !tap_first) |-> $past(tap_valid));

endmodule

// File: rtl/cc_mac.sv
module cc_mac #(
    parameter int PIX_W  = 8,
    parameter int ACC_W  = 26,
    parameter int RES_AW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tap_valid,
    input  logic              tap_first,
    input  logic              tap_last,
    input  logic              tap_final,
    input  logic [RES_AW-1:0] tap_idx,
    input  logic [PIX_W-1:0]  pix_a,
    input  logic [PIX_W-1:0]  pix_b,
    output logic              wr_en,
    output logic [RES_AW-1:0] wr_addr,
    output logic [ACC_W-1:0]  wr_data,
    output logic              done
);
    typedef struct packed {
        logic              v;
        logic              first;
        logic              last;
        logic              fin;
        logic [RES_AW-1:0] idx;
        logic [ACC_W-1:0]  acc;
        logic              wr_en;
        logic              wr_fin;
        logic [RES_AW-1:0] wr_addr;
        logic [ACC_W-1:0]  wr_data;
        logic              done;
    } mac_t;

    mac_t q, d;
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] sum;

    always_comb begin
        prod = ACC_W'(pix_a) * ACC_W'(pix_b);
        sum  = (q.first ? '0 : q.acc) + prod;
        d = q;
        // stage 1: flags delayed to meet buffer data
        d.v     = tap_valid;
        d.first = tap_first;
        d.last  = tap_last;
        d.fin   = tap_final;
        d.idx   = tap_idx;
        // stage 2: accumulate and hand the finished sum to storage
        if (q.v) begin
            d.acc = sum;
        end
        d.wr_en  = q.v && q.last;
        d.wr_fin = q.v && q.last && q.fin;
        if (q.v && q.last) begin
            d.wr_addr = q.idx;
            d.wr_data = sum;
        end
        d.done = q.wr_fin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign done    = q.done;

    // R3: the running sum never wraps within one shift
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (q.v && !q.first) |-> (sum >= q.acc));

    // R7: done follows a result write
    a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en));

    // R7: done lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/cc_result_ram.sv
module cc_result_ram #(
    parameter int DEPTH = 81,
    parameter int AW    = 7,
    parameter int DW    = 26
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/subarea_correlator.sv
module subarea_correlator
    import cc_pkg::*;
#(
    parameter int WIN_W  = 40,
    parameter int WIN_D  = 40,
    parameter int SUB_W  = 32,
    parameter int SUB_D  = 32,
    parameter int STEP   = 1,
    parameter int PIX_W  = 8,
    localparam int NS     = int'(cc_positions(WIN_W, SUB_W, STEP)),
    localparam int NT     = int'(cc_positions(WIN_D, SUB_D, STEP)),
    localparam int NSHIFT = NS * NT,
    localparam int BUF_AW = int'(cc_bits(WIN_W * WIN_D)),
    localparam int RES_AW = int'(cc_bits(NSHIFT)),
    localparam int ACC_W  = 2 * PIX_W + $clog2(SUB_W * SUB_D)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [BUF_AW-1:0] sub_addr,
    input  logic [PIX_W-1:0]  sub_pix,
    output logic [BUF_AW-1:0] win_addr,
    input  logic [PIX_W-1:0]  win_pix,
    input  logic [RES_AW-1:0] res_rd_addr,
    output logic [ACC_W-1:0]  res_rd_data,
    output logic              done
);
    logic              tap_valid, tap_first, tap_last, tap_final;
    logic [RES_AW-1:0] tap_idx;
    logic              wr_en;
    logic [RES_AW-1:0] wr_addr;
    logic [ACC_W-1:0]  wr_data;

    cc_addr_gen #(
        .WIN_W (WIN_W), .WIN_D (WIN_D), .SUB_W (SUB_W), .SUB_D (SUB_D),
        .STEP  (STEP),  .BUF_AW(BUF_AW), .RES_AW(RES_AW)
    ) u_addr_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .sub_addr (sub_addr),
        .win_addr (win_addr),
        .tap_valid(tap_valid),
        .tap_first(tap_first),
        .tap_last (tap_last),
        .tap_final(tap_final),
        .tap_idx  (tap_idx)
    );

    cc_mac #(
        .PIX_W (PIX_W), .ACC_W(ACC_W), .RES_AW(RES_AW)
    ) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_valid(tap_valid),
        .tap_first(tap_first),
        .tap_last (tap_last),
        .tap_final(tap_final),
        .tap_idx  (tap_idx),
        .pix_a    (sub_pix),
        .pix_b    (win_pix),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .done     (done)
    );

    cc_result_ram #(
        .DEPTH(NSHIFT), .AW(RES_AW), .DW(ACC_W)
    ) u_result_ram (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(res_rd_addr),
        .rd_data(res_rd_data)
    );

    // R4: results only land inside the result memory
    a_r4_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < NSHIFT));

    // R7: the final write carries the last offset index
    a_r7_last_index: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (int'($past(wr_addr)) == NSHIFT - 1));

endmodule

// File: tb/subarea_correlator_bench.sv
`timescale 1ns/1ps
module subarea_correlator_bench;
    localparam int WW = 6, WD = 5, SW = 3, SD = 2;
    localparam int SX0 = 1, SY0 = 1;
    localparam int NS1 = 4, NT1 = 4, NS2 = 2, NT2 = 2;
    localparam int NVEC = 5;
    // fields: {mul_a, add_a, mul_b, add_b}; A[i]=(i*mul_a+add_a)%256, B[i]=(i*i*mul_b+add_b)%256
    localparam logic [31:0] VEC [NVEC] = '{
        32'h00000000, 32'h00FF00FF, 32'h01000007, 32'h250B0DC8, 32'h05035B11
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, start1, start2;
    logic [4:0]  sa1, wa1, sa2, wa2;
    logic [7:0]  sp1, wp1, sp2, wp2;
    logic [3:0]  ra1;
    logic [1:0]  ra2;
    logic [18:0] rd1, rd2;
    logic        done1, done2;

    int memA [WW*WD];
    int memB [WW*WD];
    int n_chk = 0;
    int n_fail = 0;

    subarea_correlator #(.WIN_W(WW), .WIN_D(WD), .SUB_W(SW), .SUB_D(SD), .STEP(1), .PIX_W(8))
    u_subarea_correlator (
        .clk(clk), .rst_n(rst_n), .start(start1),
        .sub_addr(sa1), .sub_pix(sp1), .win_addr(wa1), .win_pix(wp1),
        .res_rd_addr(ra1), .res_rd_data(rd1), .done(done1)
    );

    subarea_correlator #(.WIN_W(WW), .WIN_D(WD), .SUB_W(SW), .SUB_D(SD), .STEP(2), .PIX_W(8))
    u_step2 (
        .clk(clk), .rst_n(rst_n), .start(start2),
        .sub_addr(sa2), .sub_pix(sp2), .win_addr(wa2), .win_pix(wp2),
        .res_rd_addr(ra2), .res_rd_data(rd2), .done(done2)
    );

    // buffers with one-cycle read latency
    always @(posedge clk) begin
        sp1 <= 8'(memA[int'(sa1) % (WW*WD)]);
        wp1 <= 8'(memB[int'(wa1) % (WW*WD)]);
        sp2 <= 8'(memA[int'(sa2) % (WW*WD)]);
        wp2 <= 8'(memB[int'(wa2) % (WW*WD)]);
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill(input logic [31:0] v);
        for (int i = 0; i < WW*WD; i++) begin
            memA[i] = (i * int'(v[31:24]) + int'(v[23:16])) % 256;
            memB[i] = (i * i * int'(v[15:8]) + int'(v[7:0])) % 256;
        end
    endtask

    function automatic longint expc(input int s, input int t, input int step);
        longint acc = 0;
        for (int y = 0; y < SD; y++)
            for (int x = 0; x < SW; x++)
                acc += longint'(memA[(y+SY0)*WW + x + SX0]) *
                       longint'(memB[(y+t*step)*WW + x + s*step]);
        return acc;
    endfunction

    // start one instance; optional stray start mid-scan; returns cycles to done
    task automatic run(input int which, input bit stray, output int cyc);
        @(negedge clk);
        if (which == 1) start1 = 1'b1; else start2 = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start1 = 1'b0; start2 = 1'b0;
        cyc = 0;
        while (((which == 1) ? done1 : done2) !== 1'b1 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (stray && cyc == 10) begin
                if (which == 1) start1 = 1'b1; else start2 = 1'b1;
            end else begin
                start1 = 1'b0; start2 = 1'b0;
            end
        end
        if (cyc >= 2000) check("watchdog run", cyc, 0);
    endtask

    task automatic rdres(input int which, input int idx, output longint val);
        @(negedge clk);
        if (which == 1) ra1 = 4'(idx); else ra2 = 2'(idx);
        @(negedge clk);
        val = (which == 1) ? longint'(rd1) : longint'(rd2);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        longint val;
        rst_n = 1'b0; start1 = 1'b0; start2 = 1'b0; ra1 = '0; ra2 = '0;
        fill(VEC[0]);
        repeat (3) @(negedge clk);
        // R1: reset and idle state
        check("R1 done low in reset", longint'(done1), 0);
        check("R1 idle sub_addr", longint'(sa1), SY0*WW + SX0);
        check("R1 idle win_addr", longint'(wa1), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done low after reset", longint'(done1), 0);

        // vector table: every offset of every pattern (R2, R4, R9)
        for (int v = 0; v < NVEC; v++) begin
            fill(VEC[v]);
            run(1, 1'b0, cyc);
            check("R6 start to done cycles", cyc, NS1*NT1*SW*SD + 2);
            for (int t = 0; t < NT1; t++)
                for (int s = 0; s < NS1; s++) begin
                    rdres(1, t*NS1 + s, val);
                    check("R2 R4 R9 correlation at t*NS+s", val, expc(s, t, 1));
                end
        end

        // R3: full scale exact
        fill(VEC[1]);
        run(1, 1'b0, cyc);
        rdres(1, NS1*NT1 - 1, val);
        check("R3 full scale sum", val, longint'(SW*SD*255*255));

        // R7: done is a single pulse
        fill(VEC[3]);
        run(1, 1'b0, cyc);
        @(negedge clk);
        check("R7 done one cycle", longint'(done1), 0);

        // R8: stray start mid-scan ignored
        fill(VEC[4]);
        run(1, 1'b1, cyc);
        check("R8 cycles unchanged with stray start", cyc, NS1*NT1*SW*SD + 2);
        begin
            int extra = 0;
            for (int k = 0; k < 150; k++) begin
                @(negedge clk);
                if (done1) extra++;
            end
            check("R8 no second done", extra, 0);
        end
        for (int i = 0; i < NS1*NT1; i++) begin
            rdres(1, i, val);
            check("R8 sums intact", val, expc(i % NS1, i / NS1, 1));
        end

        // R5: stride of two
        for (int v = 2; v < NVEC; v++) begin
            fill(VEC[v]);
            run(2, 1'b0, cyc);
            check("R5 R6 step2 cycles", cyc, NS2*NT2*SW*SD + 2);
            for (int t = 0; t < NT2; t++)
                for (int s = 0; s < NS2; s++) begin
                    rdres(2, t*NS2 + s, val);
                    check("R5 step2 correlation", val, expc(s, t, 2));
                end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule